// File: doc/BRIEF.md
# Serial DAC Input Loading Interface

This block is the digital front end of a 12-bit serial-input converter. A serial word is shifted into a 16-bit input register. The shift is framed by an active-low frame strobe and clocked on the falling edges of a serial clock. A bit counter closes a gate after sixteen accepted edges, so a continuous serial clock and a burst clock both deliver exactly one word per frame. A separate active-low load strobe copies the low twelve bits of the input register into the output latch. The latch alone drives the parallel converter code.

All serial-side inputs are asynchronous to the system clock. Each one passes through a synchronizer, and edges are found by comparing the synchronized value with its value one system clock earlier. A chain-enable input switches to daisy-chain operation. In that mode the sixteen-edge gate is off, data shifts for as long as the frame strobe is low, and the top bit of the input register is driven out serially for the next device in the chain. An active-low clear zeroes the latch and wins over the load strobe.

Top module: `serial_dac_if`

## Requirements
- R1: After reset, the latch output is 0, the serial output is 0, and the input register accepts no bits until a frame strobe falling edge is seen.
- R2: The word is sent most significant bit first. After sixteen bits, a low load strobe sets the latch to the last twelve bits sent, with the last bit sent in bit 0. The first four bits sent are not used.
- R3: When chain-enable is 0 (standalone mode), serial clock falling edges after the sixteenth in a frame have no effect on the input register.
- R4: Serial clock edges while the frame strobe is high have no effect on the input register.
- R5: While the load strobe is high, the latch output keeps its value, whatever happens on the serial inputs.
- R6: A low clear sets the latch to 0 and takes priority over a low load strobe.
- R7: When chain-enable is 1, every falling edge inside a frame shifts, and the serial output carries bit 15 of the input register. That bit is the one sent sixteen edges earlier.
- R8: A frame that ends after fewer than sixteen bits leaves a partial word, meaning the old contents shifted up by the number of bits received. The load strobe transfers that partial word.
- R9: A frame strobe falling edge restarts the bit count, so each new standalone frame accepts sixteen more bits.
- R10: In standalone mode the serial output also shows bit 15 of the input register, which after a full frame is the first bit of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, data taken on its falling edge |
| sync_ni | input | 1 | Active-low frame strobe |
| sdin_i | input | 1 | Serial data in |
| chain_en_i | input | 1 | 0 selects standalone mode, 1 selects daisy-chain mode |
| ldac_ni | input | 1 | Active-low, level-sensitive load strobe |
| clr_ni | input | 1 | Active-low latch clear |
| dac_o | output | 12 | Latched converter code |
| sdo_o | output | 1 | Serial output, bit 15 of the input register |

## Verification
The bench goes after a serial clock that keeps running past sixteen edges in standalone mode. A design without the gate would shift the don't-care bits out of the latched field and load a rotated code. Frames cut short and frames sent with the strobe high check that a partial word keeps the old register bits, and that a design which shifts outside a frame shows up as a corrupted latch. The bench asserts clear and load together to catch the wrong priority. Long chain-mode frames check that the serial output lags the input by exactly sixteen edges, which catches off-by-one taps and gating left on in chain mode.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int SR_W = 16;
  localparam int DAC_W = 12;
  localparam int SYNC_STAGES = 2;
  localparam int CNT_W = $clog2(SR_W + 1);
  localparam int N_IN = 6;
  // synchronized input order, LSB first: sclk, sync_n, ldac_n, clr_n, sdin, chain
  localparam logic [N_IN-1:0] IN_RST = 6'b001111;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int N = 6,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RST_VAL[b]}};
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
  parameter int W = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          sync_ni,
  input  logic          sdin_i,
  input  logic          chain_i,
  output logic [W-1:0]  sr_o,
  output logic          sdo_o,
  output logic [CW-1:0] cnt_o,
  output logic          sync_fall_o,
  output logic          shift_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);

  logic          sclk_q, sync_q;
  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          sclk_fall, sync_fall, gate_open, shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      sync_q <= sync_ni;
    end
  end

  assign sclk_fall = sclk_q & ~sclk_i;
  assign sync_fall = sync_q & ~sync_ni;
  // gate closes after W accepted edges unless chaining
  assign gate_open = chain_i | (cnt_q != CNT_FULL);
  assign shift     = sclk_fall & ~sync_ni & ~sync_fall & gate_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= CNT_FULL;
    else if (sync_fall)                   cnt_q <= '0;
    else if (shift && cnt_q != CNT_FULL)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (shift) sr_q <= {sr_q[W-2:0], sdin_i};
  end

  assign sr_o        = sr_q;
  assign sdo_o       = sr_q[W-1];
  assign cnt_o       = cnt_q;
  assign sync_fall_o = sync_fall;
  assign shift_o     = shift;
endmodule

// File: rtl/dacif_latch.sv
module dacif_latch #(
  parameter int W = 16,
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ldac_ni,
  input  logic          clr_ni,
  input  logic [W-1:0]  sr_i,
  output logic [DW-1:0] dac_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dac_o <= '0;
    else if (!clr_ni)  dac_o <= '0;
    else if (!ldac_ni) dac_o <= sr_i[DW-1:0];
  end
endmodule

// File: rtl/serial_dac_if.sv
module serial_dac_if
  import dacif_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sync_ni,
  input  logic             sdin_i,
  input  logic             chain_en_i,
  input  logic             ldac_ni,
  input  logic             clr_ni,
  output logic [DAC_W-1:0] dac_o,
  output logic             sdo_o
);
  logic [N_IN-1:0]  raw, syn;
  logic             sclk_s, sync_s, ldac_s, clr_s, sdin_s, chain_s;
  logic [SR_W-1:0]  sr;
  logic [CNT_W-1:0] cnt;
  logic             sync_fall, shift;

  assign raw = {chain_en_i, sdin_i, clr_ni, ldac_ni, sync_ni, sclk_i};

  dacif_sync #(.N(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign {chain_s, sdin_s, clr_s, ldac_s, sync_s, sclk_s} = syn;

  dacif_shifter #(.W(SR_W), .CW(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_s), .sync_ni(sync_s),
    .sdin_i(sdin_s), .chain_i(chain_s), .sr_o(sr), .sdo_o(sdo_o),
    .cnt_o(cnt), .sync_fall_o(sync_fall), .shift_o(shift)
  );

  dacif_latch #(.W(SR_W), .DW(DAC_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .ldac_ni(ldac_s), .clr_ni(clr_s),
    .sr_i(sr), .dac_o(dac_o)
  );
endmodule

// File: rtl/serial_dac_if_chk.sv
module serial_dac_if_chk
  import dacif_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DAC_W-1:0] dac_o,
  input logic             sdo_o,
  input logic             clr_s,
  input logic             ldac_s,
  input logic             sync_s,
  input logic             chain_s,
  input logic             sync_fall,
  input logic [CNT_W-1:0] cnt,
  input logic [SR_W-1:0]  sr
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SR_W);

  p_clr_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_s |=> dac_o == '0);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_s && ldac_s) |=> $stable(dac_o));

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_s && !ldac_s) |=> dac_o == $past(sr[DAC_W-1:0]));

  p_idle_sr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_s |=> $stable(sr));

  p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chain_s && cnt == FULL && !sync_fall) |=> $stable(sr));

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= FULL);

  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_fall |=> cnt == '0);

  p_sdo_tap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_o == sr[SR_W-1]);
endmodule

bind serial_dac_if serial_dac_if_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dac_o(dac_o), .sdo_o(sdo_o),
  .clr_s(clr_s), .ldac_s(ldac_s), .sync_s(sync_s), .chain_s(chain_s),
  .sync_fall(sync_fall), .cnt(cnt), .sr(sr)
);

// File: tb/serial_dac_if_tb.sv
module serial_dac_if_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, chain = 1'b0;
  logic ldac_n = 1'b1, clr_n = 1'b1;
  logic [11:0] dac;
  logic sdo;

  int checks = 0, failures = 0;
  logic [15:0] m_sr = '0;
  logic [11:0] m_dac = '0;
  int m_cnt = 16;

  always #4 clk = ~clk;

  serial_dac_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sync_ni(sync_n),
    .sdin_i(sdin), .chain_en_i(chain), .ldac_ni(ldac_n), .clr_ni(clr_n),
    .dac_o(dac), .sdo_o(sdo)
  );

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] shift_in(logic [15:0] r, logic b);
    return {r[14:0], b};
  endfunction

  task automatic send_bit(logic b);
    sdin = b;
    wclk(6);
    sclk = 1'b0;
    if (!sync_n && (chain || m_cnt < 16)) begin
      m_sr = shift_in(m_sr, b);
      if (m_cnt < 16) m_cnt++;
    end
    wclk(6);
    sclk = 1'b1;
  endtask

  task automatic start_frame();
    sync_n = 1'b0; m_cnt = 0; wclk(6);
  endtask

  task automatic end_frame();
    wclk(6); sync_n = 1'b1; wclk(6);
  endtask

  task automatic send_word(logic [15:0] w, int nbits);
    for (int i = 0; i < nbits; i++) send_bit(i < 16 ? w[15-i] : 1'($urandom));
  endtask

  task automatic load();
    ldac_n = 1'b0; wclk(8);
    ldac_n = 1'b1; wclk(6);
    m_dac = m_sr[11:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd4242));
    wclk(3); rst_n = 1'b1; wclk(4);
    chk("R1 dac", {4'h0, dac}, 16'h0);
    chk("R1 sdo", {15'h0, sdo}, 16'h0);
    // R1: no frame yet -> clocks ignored
    send_word(16'hFFFF, 4);
    load();
    chk("R1 gated", {4'h0, dac}, 16'h0);

    // R2 / R10 directed
    start_frame(); send_word(16'hA5C3, 16); end_frame();
    chk("R5 no load yet", {4'h0, dac}, 16'h0);
    chk("R10 sdo", {15'h0, sdo}, 16'h1);
    load();
    chk("R2 word", {4'h0, dac}, 16'h05C3);

    // R3 continuous clock past 16
    start_frame(); send_word(16'h7123, 22); end_frame();
    load();
    chk("R3 extra edges", {4'h0, dac}, 16'h0123);
    chk("R10 sdo", {15'h0, sdo}, 16'h0);

    // R4 edges with strobe high
    send_word(16'hFFFF, 8);
    load();
    chk("R4 idle edges", {4'h0, dac}, 16'h0123);

    // R8 partial frame
    start_frame(); send_word(16'hB000, 5); end_frame();
    load();
    chk("R8 partial", {4'h0, dac}, {4'h0, m_dac});
    chk("R8 partial value", {4'h0, dac}, 16'h0476);

    // R6 clear wins over load
    clr_n = 1'b0; ldac_n = 1'b0; wclk(8);
    chk("R6 clr priority", {4'h0, dac}, 16'h0);
    clr_n = 1'b1; ldac_n = 1'b1; wclk(6);
    chk("R6 after clr", {4'h0, dac}, 16'h0);
    m_dac = '0;

    // R9 back-to-back frames
    start_frame(); send_word(16'h1111, 16); end_frame();
    start_frame(); send_word(16'h2ABC, 16); end_frame();
    load();
    chk("R9 second frame", {4'h0, dac}, 16'h0ABC);

    // R7 daisy chain
    chain = 1'b1; wclk(6);
    start_frame();
    send_word(16'h8000, 16);
    send_word(16'h0000, 1);
    chk("R7 chain delay", {15'h0, sdo}, 16'h0);
    chk("R7 chain model", m_sr, 16'h0000);
    for (int i = 0; i < 24; i++) begin
      send_bit(1'($urandom));
      chk("R7 sdo tap", {15'h0, sdo}, {15'h0, m_sr[15]});
    end
    end_frame();
    load();
    chk("R7 chain load", {4'h0, dac}, {4'h0, m_dac});
    chain = 1'b0; wclk(6);

    // random mixed frames
    for (int it = 0; it < 30; it++) begin
      w = 16'($urandom);
      start_frame();
      send_word(w, 10 + int'($urandom % 12));
      end_frame();
      chk("R5 hold", {4'h0, dac}, {4'h0, m_dac});
      if ($urandom % 4 == 0) begin
        clr_n = 1'b0; wclk(8); clr_n = 1'b1; wclk(6);
        m_dac = '0;
        chk("R6 random clr", {4'h0, dac}, 16'h0);
      end else begin
        load();
        chk("R2 random", {4'h0, dac}, {4'h0, m_dac});
        chk("R10 random sdo", {15'h0, sdo}, {15'h0, m_sr[15]});
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule